// File: doc/BRIEF.md
# Multicarrier Sinusoidal PWM Level Modulator

This block produces the switch-position command for one leg of an n-level diode-clamped inverter. It compares a digital sinusoidal reference with n-1 digital triangular carriers. The result is a level index from 0 to n-1, the same level as a one-hot position vector, and a set of complementary upper/lower gate pairs. The level count n (3, 4 or 5) is chosen at run time. The carriers can be stacked in adjacent level bands, with three phase arrangements. They can also each span the full range, each one shifted in time by an equal fraction of the carrier period.

A shared carrier-phase counter and a reference-step counter move forward once per `sample_en` strobe, so the strobe rate sets the switching frequency. The reference completes one period in 21 carrier periods. Its amplitude is scaled by an 8-bit modulation-index word, where 230 stands for about 0.9. All outputs are registered.

Top module: `mc_spwm_level`

## Requirements
- R1: While `rst_n` is low, and until the first clock edge after reset, the block holds `level_idx` = 0, `pos_onehot` = 1 (bit 0 set), all `gate_up` bits at 0, all `gate_lo` bits at 1 and `mode_err` at 0. Reset starts the carrier phase p and the reference step e at 0.
- R2: p and e change only on a clock edge where `sample_en` is 1. There, p advances by 1 modulo 64. The step counter advances e by 1 modulo 64 once every 21 strobes, so with t strobes since reset, p = t mod 64 and e = floor(t/21) mod 64. The triangle value is tri(p) = 32 - |p - 32|, ranging from 0 to 32.
- R3: Let the reference be ref = mid + amp for e < 32 and ref = mid - amp otherwise. Here mid = 16·(n-1), amp = floor(mid·mi·mag / 65536), mag = x·(32-x) with x = e mod 32, and mi is `mod_index`.
- R4: With `mode_sel` = 0 (bands, all in phase), carrier c (c = 0 to n-2) equals 32·c + tri(p). `level_idx` is the number of carriers strictly below ref.
- R5: With `mode_sel` = 1 (bands, alternate carriers inverted), every odd c uses 32·c + 32 - tri(p) and every even c uses 32·c + tri(p). The level is counted as in R4.
- R6: With `mode_sel` = 2 (bands, lower half inverted) and n odd, every carrier with 2·c < n-1 uses 32·c + 32 - tri(p) and the rest use 32·c + tri(p). The level is counted as in R4.
- R7: `mode_sel` = 2 with an even n sets `mode_err` to 1, and the block then behaves exactly as `mode_sel` = 0. In every other case `mode_err` is 0.
- R8: With `mode_sel` = 3 (time-shifted full-range carriers), carrier c equals (n-1)·tri(q) with q = (p - floor(64·c/(n-1))) mod 64. `level_idx` is the number of carriers strictly below ref.
- R9: `pos_onehot` has exactly one bit set, and that bit is the one at position `level_idx`.
- R10: `gate_up[i]` is 1 exactly when i < `level_idx`, and `gate_lo[i]` is always the inverse of `gate_up[i]`.
- R11: A `level_cnt` below 3 is used as 3 and a value above 5 is used as 5. `level_idx` never exceeds n-1.
- R12: Outputs are registered. A change of `mode_sel`, `level_cnt` or `mod_index`, or of p and e, shows up at the outputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Advance strobe for the carrier and reference counters |
| mode_sel | input | 2 | Carrier arrangement: 0 in phase, 1 alternate inverted, 2 lower half inverted, 3 time-shifted |
| level_cnt | input | 3 | Requested level count n (3 to 5, clamped) |
| mod_index | input | 8 | Modulation index, scaled by 1/256 |
| pos_onehot | output | 5 | One-hot switch position |
| level_idx | output | 3 | Binary level index |
| gate_up | output | 4 | Upper switch commands |
| gate_lo | output | 4 | Lower switch commands, inverse of gate_up |
| mode_err | output | 1 | Lower-half-inverted mode requested with an even level count |

## Verification
The level output is compared, strobe by strobe, with an independent comparison model under all four carrier arrangements at every level count. One of these runs covers a whole reference period. Running the same reference against the in-phase, alternate-inverted and lower-half-inverted bands separates the three band arrangements. The time-shifted runs at n = 3, 4 and 5 expose a wrong delay per carrier, including the inexact division by 3. A zero and a full-scale modulation index test the amplitude scaling at its ends. An even count in lower-half-inverted mode tests the error flag and the fallback. Directed cases cover hold without a strobe, the one-edge latency, clamping of the level count, and a reset in the middle of a run.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

  typedef enum logic [1:0] {
    MODE_INPHASE = 2'd0,
    MODE_ALTINV  = 2'd1,
    MODE_HALFINV = 2'd2,
    MODE_SHIFTED = 2'd3
  } carrier_mode_e;

  // Triangle height at phase ph for a half-period of 'half' steps.
  function automatic int tri_val(input int ph, input int half);
    return (ph <= half) ? ph : (2 * half) - ph;
  endfunction

  // Parabolic half-wave magnitude, full scale 256 at the crest.
  function automatic int sine_mag(input int idx, input int cw);
    int half;
    int x;
    half = 1 << cw;
    x    = idx & (half - 1);
    return (4 * x * (half - x)) >>> (2 * cw - 8);
  endfunction

  // Reference value in carrier units; idx spans one full period of 2*half steps.
  function automatic int ref_level(input int idx, input int nm1, input int mi,
                                   input int cw, input int mi_w);
    int half;
    int mid;
    int amp;
    half = 1 << cw;
    mid  = (nm1 * half) / 2;
    amp  = (mid * mi * sine_mag(idx, cw)) >>> (mi_w + 8);
    return (idx >= half) ? mid - amp : mid + amp;
  endfunction

  // Time offset of carrier k in the shifted arrangement, in phase steps.
  function automatic int shift_delay(input int k, input int nm1, input int tp);
    int d;
    case (nm1)
      2:       d = (k * tp) / 2;
      3:       d = (k * tp) / 3;
      default: d = (k * tp) / 4;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase #(
  parameter int CW    = 5,
  parameter int RATIO = 21
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en,
  output logic [CW:0] car_ph,
  output logic [CW:0] ref_idx
);
  localparam int SUB_W = $clog2(RATIO);

  logic [SUB_W-1:0] sub_q;
  logic             ref_step;

  assign ref_step = sample_en && (sub_q == SUB_W'(RATIO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_ph  <= '0;
      sub_q   <= '0;
      ref_idx <= '0;
    end else if (sample_en) begin
      car_ph <= car_ph + 1'b1;
      if (ref_step) begin
        sub_q   <= '0;
        ref_idx <= ref_idx + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcpwm_compare.sv
module mcpwm_compare
  import mcpwm_pkg::*;
#(
  parameter int CW   = 5,
  parameter int NMAX = 5,
  parameter int MI_W = 8,
  parameter int LW   = 3
) (
  input  logic [CW:0]     car_ph,
  input  logic [CW:0]     ref_idx,
  input  carrier_mode_e   mode_eff,
  input  logic [2:0]      nm1,
  input  logic [MI_W-1:0] mod_index,
  output logic [LW-1:0]   level
);
  localparam int H  = 1 << CW;
  localparam int TP = 2 * H;
  localparam int VW = $clog2((NMAX - 1) * H + 1);

  logic [VW-1:0]   ref_val;
  logic [NMAX-2:0] win;

  always_comb begin
    ref_val = VW'(ref_level(int'(ref_idx), int'(nm1), int'(mod_index), CW, MI_W));
  end

  genvar k;
  generate
    for (k = 0; k < NMAX - 1; k++) begin : g_car
      always_comb begin : p_car
        int tp_v;
        int val;
        int pk;
        tp_v = tri_val(int'(car_ph), H);
        pk   = 0;
        case (mode_eff)
          MODE_ALTINV:  val = ((k % 2) == 1) ? (k * H + H - tp_v) : (k * H + tp_v);
          MODE_HALFINV: val = (k < int'(nm1) / 2) ? (k * H + H - tp_v) : (k * H + tp_v);
          MODE_SHIFTED: begin
            pk  = (int'(car_ph) - shift_delay(k, int'(nm1), TP) + TP) & (TP - 1);
            val = int'(nm1) * tri_val(pk, H);
          end
          default:      val = k * H + tp_v;
        endcase
        win[k] = (k < int'(nm1)) && (val < int'(ref_val));
      end
    end
  endgenerate

  always_comb begin
    level = '0;
    for (int c = 0; c < NMAX - 1; c++) level = level + LW'(win[c]);
  end
endmodule

// File: rtl/mcpwm_gate_map.sv
module mcpwm_gate_map #(
  parameter int NMAX = 5,
  parameter int LW   = 3
) (
  input  logic [LW-1:0]   level,
  output logic [NMAX-1:0] pos,
  output logic [NMAX-2:0] up,
  output logic [NMAX-2:0] lo
);
  genvar j;
  generate
    for (j = 0; j < NMAX; j++) begin : g_pos
      assign pos[j] = (int'(level) == j);
    end
    for (j = 0; j < NMAX - 1; j++) begin : g_sw
      assign up[j] = (int'(level) > j);
      assign lo[j] = !up[j];
    end
  endgenerate
endmodule

// File: rtl/mc_spwm_level.sv
module mc_spwm_level
  import mcpwm_pkg::*;
#(
  parameter int CW    = 5,
  parameter int RATIO = 21,
  parameter int NMAX  = 5,
  parameter int MI_W  = 8,
  localparam int LW   = $clog2(NMAX)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_en,
  input  logic [1:0]      mode_sel,
  input  logic [2:0]      level_cnt,
  input  logic [MI_W-1:0] mod_index,
  output logic [NMAX-1:0] pos_onehot,
  output logic [LW-1:0]   level_idx,
  output logic [NMAX-2:0] gate_up,
  output logic [NMAX-2:0] gate_lo,
  output logic            mode_err
);
  logic [CW:0]     car_ph;
  logic [CW:0]     ref_idx;
  logic [2:0]      n_eff;
  logic [2:0]      nm1;
  logic            a3_bad;
  carrier_mode_e   mode_req;
  carrier_mode_e   mode_eff;
  logic [LW-1:0]   lvl_d;
  logic [NMAX-1:0] pos_d;
  logic [NMAX-2:0] up_d;
  logic [NMAX-2:0] lo_d;

  always_comb begin
    if (level_cnt < 3'd3)               n_eff = 3'd3;
    else if (int'(level_cnt) > NMAX)    n_eff = 3'(NMAX);
    else                                n_eff = level_cnt;
    nm1      = n_eff - 3'd1;
    mode_req = carrier_mode_e'(mode_sel);
    a3_bad   = (mode_req == MODE_HALFINV) && !n_eff[0];
    mode_eff = a3_bad ? MODE_INPHASE : mode_req;
  end

  mcpwm_timebase #(.CW(CW), .RATIO(RATIO)) u_tb (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .car_ph(car_ph), .ref_idx(ref_idx)
  );

  mcpwm_compare #(.CW(CW), .NMAX(NMAX), .MI_W(MI_W), .LW(LW)) u_cmp (
    .car_ph(car_ph), .ref_idx(ref_idx), .mode_eff(mode_eff),
    .nm1(nm1), .mod_index(mod_index), .level(lvl_d)
  );

  mcpwm_gate_map #(.NMAX(NMAX), .LW(LW)) u_map (
    .level(lvl_d), .pos(pos_d), .up(up_d), .lo(lo_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_idx  <= '0;
      pos_onehot <= NMAX'(1);
      gate_up    <= '0;
      gate_lo    <= '1;
      mode_err   <= 1'b0;
    end else begin
      level_idx  <= lvl_d;
      pos_onehot <= pos_d;
      gate_up    <= up_d;
      gate_lo    <= lo_d;
      mode_err   <= a3_bad;
    end
  end
endmodule

// File: rtl/mcpwm_checker.sv
module mcpwm_checker #(
  parameter int CW   = 5,
  parameter int NMAX = 5,
  parameter int LW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sample_en,
  input logic [1:0]      mode_sel,
  input logic [2:0]      n_eff,
  input logic [CW:0]     car_ph,
  input logic [CW:0]     ref_idx,
  input logic [NMAX-1:0] pos_onehot,
  input logic [LW-1:0]   level_idx,
  input logic [NMAX-2:0] gate_up,
  input logic [NMAX-2:0] gate_lo,
  input logic            mode_err
);
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pos_onehot) == 1);

  a_r9_pos_level: assert property (@(posedge clk) disable iff (!rst_n)
    pos_onehot[level_idx] == 1'b1);

  a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo == ~gate_up);

  a_r10_gate_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_up) == int'(level_idx));

  a_r11_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> int'(level_idx) < int'($past(n_eff)));

  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'd2 && !n_eff[0]) |=> mode_err);

  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_sel == 2'd2 && !n_eff[0]) |=> !mode_err);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(car_ph) && $stable(ref_idx)));

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> car_ph == $past(car_ph) + 1'b1);
endmodule

bind mc_spwm_level mcpwm_checker #(.CW(CW), .NMAX(NMAX), .LW(LW)) u_mcpwm_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .mode_sel(mode_sel),
  .n_eff(n_eff), .car_ph(car_ph), .ref_idx(ref_idx),
  .pos_onehot(pos_onehot), .level_idx(level_idx), .gate_up(gate_up),
  .gate_lo(gate_lo), .mode_err(mode_err)
);

// File: tb/test_mc_spwm_level.sv
`timescale 1ns/1ps
module test_mc_spwm_level;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_en = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [2:0] level_cnt = 3'd5;
  logic [7:0] mod_index = 8'd230;
  logic [4:0] pos_onehot;
  logic [2:0] level_idx;
  logic [3:0] gate_up;
  logic [3:0] gate_lo;
  logic       mode_err;

  int checks = 0;
  int fails  = 0;
  int t      = 0;

  always #4 clk = ~clk;

  mc_spwm_level i_mc_spwm_level (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .mode_sel(mode_sel),
    .level_cnt(level_cnt), .mod_index(mod_index), .pos_onehot(pos_onehot),
    .level_idx(level_idx), .gate_up(gate_up), .gate_lo(gate_lo), .mode_err(mode_err)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  n;
    logic [7:0]  mi;
    logic [15:0] ticks;
    logic        err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd5, 8'd230, 16'd1344, 1'b0},
    '{2'd0, 3'd3, 8'd230, 16'd100,  1'b0},
    '{2'd0, 3'd4, 8'd200, 16'd100,  1'b0},
    '{2'd1, 3'd5, 8'd230, 16'd150,  1'b0},
    '{2'd1, 3'd4, 8'd230, 16'd100,  1'b0},
    '{2'd1, 3'd3, 8'd255, 16'd80,   1'b0},
    '{2'd2, 3'd5, 8'd230, 16'd150,  1'b0},
    '{2'd2, 3'd3, 8'd230, 16'd80,   1'b0},
    '{2'd2, 3'd4, 8'd230, 16'd80,   1'b1},
    '{2'd3, 3'd3, 8'd230, 16'd100,  1'b0},
    '{2'd3, 3'd4, 8'd230, 16'd120,  1'b0},
    '{2'd3, 3'd5, 8'd230, 16'd150,  1'b0},
    '{2'd0, 3'd5, 8'd0,   16'd70,   1'b0},
    '{2'd3, 3'd5, 8'd255, 16'd70,   1'b0}
  };

  function automatic int clamp_n(int n);
    if (n < 3) return 3;
    if (n > 5) return 5;
    return n;
  endfunction

  function automatic int absdiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Independent comparison model, restated from R2, R3, R4-R8.
  function automatic int exp_level(int tt, int mode, int n, int mi);
    int p, e, x, mag, mid, amp, r, m, cnt, tr, v, sh, q;
    bit inv;
    p   = tt % 64;
    e   = (tt / 21) % 64;
    x   = e % 32;
    mag = x * (32 - x);
    mid = (n - 1) * 16;
    amp = (mid * mi * mag) / 65536;
    r   = (e < 32) ? mid + amp : mid - amp;
    m   = (mode == 2 && (n % 2) == 0) ? 0 : mode;
    cnt = 0;
    tr  = 32 - absdiff(p, 32);
    for (int c = 0; c < n - 1; c++) begin
      if (m == 3) begin
        sh = (c * 64) / (n - 1);
        q  = (p - sh + 64) % 64;
        v  = (n - 1) * (32 - absdiff(q, 32));
      end else begin
        inv = (m == 1) ? (c % 2 == 1) : (m == 2) ? (2 * c < n - 1) : 1'b0;
        v   = inv ? 32 * c + 32 - tr : 32 * c + tr;
      end
      if (v < r) cnt++;
    end
    return cnt;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  task automatic check_outputs(string tag, int exp);
    check(tag, int'(level_idx), exp);
    check("R9 position", int'(pos_onehot), 1 << exp);
    check("R10 upper gates", int'(gate_up), (1 << exp) - 1);
    check("R10 lower gates", int'(gate_lo), (~((1 << exp) - 1)) & 15);
  endtask

  task automatic tick();
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    t++;
    @(negedge clk);
  endtask

  task automatic reset_and_check();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 level", int'(level_idx), 0);
    check("R1 position", int'(pos_onehot), 1);
    check("R1 upper gates", int'(gate_up), 0);
    check("R1 lower gates", int'(gate_lo), 15);
    check("R1 error flag", int'(mode_err), 0);
    rst_n = 1'b1;
    t = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    string tags [4];
    int ne;
    int hold_lvl;
    tags[0] = "R4 R3";
    tags[1] = "R5 R3";
    tags[2] = "R6 R3";
    tags[3] = "R8 R3";

    reset_and_check();
    check_outputs("R1 first state", exp_level(0, 0, 5, 230));

    for (int v = 0; v < NV; v++) begin
      string tg;
      mode_sel  = VECS[v].mode;
      level_cnt = VECS[v].n;
      mod_index = VECS[v].mi;
      tg = VECS[v].err ? "R7 fallback" : tags[VECS[v].mode];
      for (int s = 0; s < int'(VECS[v].ticks); s++) begin
        tick();
        check_outputs(tg, exp_level(t, int'(VECS[v].mode), int'(VECS[v].n), int'(VECS[v].mi)));
      end
      check("R7 error flag", int'(mode_err), int'(VECS[v].err));
    end

    // R2: no strobe, no movement
    mode_sel = 2'd3; level_cnt = 3'd5; mod_index = 8'd230;
    tick();
    hold_lvl = exp_level(t, 3, 5, 230);
    repeat (12) @(negedge clk);
    check_outputs("R2 hold", hold_lvl);

    // R12: input change visible after one edge
    for (int m = 0; m < 4; m++) begin
      @(negedge clk) mode_sel = 2'(m);
      @(negedge clk);
      check_outputs("R12 latency", exp_level(t, m, 5, 230));
    end

    // R11: clamping of the level count
    mode_sel = 2'd0;
    for (int c = 0; c < 8; c++) begin
      level_cnt = 3'(c);
      ne = clamp_n(c);
      for (int s = 0; s < 20; s++) begin
        tick();
        check_outputs("R11 clamp", exp_level(t, 0, ne, 230));
      end
    end
    level_cnt = 3'd6;
    mode_sel  = 2'd2;
    tick();
    check("R11 R7 clamp to odd", int'(mode_err), 0);

    // R1: reset in the middle of a run restarts phase
    mode_sel = 2'd1; level_cnt = 3'd5;
    reset_and_check();
    check_outputs("R1 R2 restart", exp_level(0, 1, 5, 230));
    for (int s = 0; s < 40; s++) begin
      tick();
      check_outputs("R5 after reset", exp_level(t, 1, 5, 230));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule